// File: doc/BRIEF.md
# Amplifier Control Serial Slave

This block is the two-wire serial slave of a four-channel power amplifier controller. It listens on already synchronized SCL and SDA lines, answers only to its fixed 7-bit address, and drives SDA low through an output-enable whenever it acknowledges a byte or sends a zero bit. The pad, and any clock stretching or arbitration, lives outside the block.

A write transaction carries two control bytes. They are stored in order and presented on a single control bus for the amplifier and diagnostic logic. A read transaction returns four status bytes from the diagnostic logic, first byte first and most significant bit first. Two bits of the third byte are replaced by echoes of control bits, and the top two bits of the fourth byte read as zero. The status word is frozen into a shift snapshot when the read address is acknowledged. When the last bit of the fourth byte leaves the block, a one-cycle pulse tells the diagnostic logic to start new measurement cycles. The bytes sent in that read therefore come from the previous cycle.

Top module: `amp_ctl_i2c_slave`

## Requirements
- R1: The address byte is seven bits `1101100` followed by a direction bit: 0xD8 writes and 0xD9 reads. Any other address gets no acknowledge (SDA stays released in the ninth clock), and `ctrl_o` is left unchanged.
- R2: In a write, the slave acknowledges each data byte. The first byte lands in `ctrl_o[7:0]` and the second in `ctrl_o[15:8]`, each committed in the acknowledge clock of that byte. A STOP after only the first byte changes only `ctrl_o[7:0]`.
- R3: A third data byte in one write is not acknowledged and leaves `ctrl_o` unchanged.
- R4: The fields of the first control byte are: bit 6 diagnostics enable, bit 5 offset check enable, bit 4 front gain low, bit 3 rear gain low, bit 2 front unmute, bit 1 rear unmute, bit 0 clip threshold select.
- R5: The fields of the second control byte are: bit 4 amplifier running (standby off), bit 3 line-driver diagnostic thresholds, bit 2 current check enable, bit 1 right-side high-efficiency mode, bit 0 left-side high-efficiency mode.
- R6: A read returns four bytes, `status_i[31:24]` first and `status_i[7:0]` last, each byte sent MSB first and each followed by a master acknowledge slot.
- R7: In the third byte, bit 7 carries control byte 2 bit 4 and bit 6 carries control byte 1 bit 6. In the fourth byte, bits 7:6 are sent as 0.
- R8: The status word is captured when the read address is acknowledged. Changes on `status_i` later in the same read do not alter the bytes sent.
- R9: `rearm_o` pulses high for exactly one clock after the eighth bit of the fourth byte has been sent. A read that ends earlier gives no pulse.
- R10: A master NACK after a read byte makes the slave release SDA and ignore further clocks until the next START.
- R11: A START while SCL is high, repeated or not, aborts any transfer and restarts address reception. A STOP returns the slave to idle. SDA drive only ever begins while SCL is low.
- R12: During and after reset, `ctrl_o` is 0 and both `sda_oe_o` and `rearm_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized serial clock line level |
| sda_i | input | 1 | Synchronized serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| status_i | input | 32 | Diagnostic status word, first-sent byte in bits 31:24 |
| ctrl_o | output | 16 | Control bytes: first written in 7:0, second in 15:8 |
| rearm_o | output | 1 | One-cycle pulse when a full four-byte read has been sent |

## Verification
The assertions assume that SCL and SDA reach the block already synchronized to `clk`. They also assume that the master changes SDA only while SCL is low, except when it makes START and STOP, and that it never issues a STOP while the slave is pulling SDA low. The bench keeps to these rules. It changes every line on the falling clock edge, holds each SCL phase for several clocks, and releases its own SDA in every acknowledge and read slot. The line is modelled as a wired-AND of the master level and the slave output-enable.

// File: rtl/amp_i2c_pkg.sv
package amp_i2c_pkg;

    localparam int BYTE_W = 8;

    // Echo of control bits into the status stream (neighbour firmware decodes these)
    localparam int ECHO_BYTE   = 2;  // third byte sent
    localparam int ECHO_HI_BIT = 7;
    localparam int ECHO_LO_BIT = 6;
    localparam int RUN_REG     = 1;  // second control byte
    localparam int RUN_BIT     = 4;
    localparam int DIAG_REG    = 0;  // first control byte
    localparam int DIAG_BIT    = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_WR,
        ST_ACK_WR,
        ST_RD,
        ST_RD_ACK,
        ST_RD_NEXT
    } link_state_t;

endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d     = line_q;
        line_d.scl = scl_i;
        line_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            line_q <= line_d;
        end
    end

    assign start_o    = line_q.scl &  scl_i &  line_q.sda & ~sda_i;
    assign stop_o     = line_q.scl &  scl_i & ~line_q.sda &  sda_i;
    assign scl_rise_o = ~line_q.scl &  scl_i;
    assign scl_fall_o =  line_q.scl & ~scl_i;

endmodule

// File: rtl/status_snapshot.sv
module status_snapshot #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              msb_o,
    output logic              next_o
);

    logic [WORD_W-1:0] snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (load_i) begin
            snap_d = word_i;
        end else if (shift_i) begin
            snap_d = {snap_q[WORD_W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '1;
        end else begin
            snap_q <= snap_d;
        end
    end

    assign msb_o  = snap_q[WORD_W-1];
    assign next_o = snap_q[WORD_W-2];

    // Capture and shifting are never requested together (frozen snapshot)
    assert_load_shift_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && shift_i));

endmodule

// File: rtl/amp_ctl_i2c_slave.sv
module amp_ctl_i2c_slave
    import amp_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6C,
    parameter int         NUM_WR   = 2,
    parameter int         NUM_RD   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe_o,
    input  logic [NUM_RD*BYTE_W-1:0] status_i,
    output logic [NUM_WR*BYTE_W-1:0] ctrl_o,
    output logic                     rearm_o
);

    localparam int WORD_W   = NUM_RD * BYTE_W;
    localparam int MAX_CNT  = (NUM_WR > NUM_RD) ? NUM_WR : NUM_RD;
    localparam int IDX_W    = $clog2(MAX_CNT + 1);
    localparam int ECHO_OFS = (NUM_RD - 1 - ECHO_BYTE) * BYTE_W;
    localparam logic [IDX_W-1:0] WR_LIMIT = IDX_W'(NUM_WR);
    localparam logic [IDX_W-1:0] RD_LAST  = IDX_W'(NUM_RD - 1);
    localparam logic [IDX_W-1:0] RD_LIMIT = IDX_W'(NUM_RD);

    typedef struct packed {
        link_state_t                    st;
        logic [3:0]                     cnt;
        logic [BYTE_W-1:0]              sh;
        logic                           rw;
        logic [IDX_W-1:0]               idx;
        logic                           oe;
        logic                           rearm;
        logic [NUM_WR-1:0][BYTE_W-1:0]  regs;
    } link_t;

    link_t n_d, n_q;

    logic ev_start, ev_stop, ev_rise, ev_fall;
    logic snap_load, snap_shift, snap_msb, snap_next;
    logic [WORD_W-1:0] snap_word;

    i2c_line_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .start_o   (ev_start),
        .stop_o    (ev_stop),
        .scl_rise_o(ev_rise),
        .scl_fall_o(ev_fall)
    );

    // Status word with echoed control bits and cleared top bits of the last byte
    always_comb begin
        snap_word = status_i;
        snap_word[ECHO_OFS + ECHO_HI_BIT] = n_q.regs[RUN_REG][RUN_BIT];
        snap_word[ECHO_OFS + ECHO_LO_BIT] = n_q.regs[DIAG_REG][DIAG_BIT];
        snap_word[BYTE_W-1:BYTE_W-2]      = 2'b00;
    end

    status_snapshot #(.WORD_W(WORD_W)) u_snapshot (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (snap_load),
        .shift_i(snap_shift),
        .word_i (snap_word),
        .msb_o  (snap_msb),
        .next_o (snap_next)
    );

    always_comb begin
        n_d        = n_q;
        n_d.rearm  = 1'b0;
        snap_load  = 1'b0;
        snap_shift = 1'b0;
        if (ev_start) begin
            n_d.st  = ST_ADDR;
            n_d.cnt = 4'd0;
            n_d.idx = '0;
            n_d.oe  = 1'b0;
        end else if (ev_stop) begin
            n_d.st = ST_IDLE;
            n_d.oe = 1'b0;
        end else begin
            unique case (n_q.st)
                ST_IDLE: ;
                ST_ADDR: begin
                    if (ev_rise && n_q.cnt != 4'd8) begin
                        n_d.sh  = {n_q.sh[BYTE_W-2:0], sda_i};
                        n_d.cnt = n_q.cnt + 4'd1;
                    end else if (ev_fall && n_q.cnt == 4'd8) begin
                        if (n_q.sh[BYTE_W-1:1] == DEV_ADDR) begin
                            n_d.st    = ST_ACK_ADDR;
                            n_d.oe    = 1'b1;
                            n_d.rw    = n_q.sh[0];
                            n_d.idx   = '0;
                            snap_load = n_q.sh[0];
                        end else begin
                            n_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (ev_fall) begin
                        n_d.cnt = 4'd0;
                        if (n_q.rw) begin
                            n_d.st = ST_RD;
                            n_d.oe = ~snap_msb;
                        end else begin
                            n_d.st = ST_WR;
                            n_d.oe = 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (ev_rise && n_q.cnt != 4'd8) begin
                        n_d.sh  = {n_q.sh[BYTE_W-2:0], sda_i};
                        n_d.cnt = n_q.cnt + 4'd1;
                    end else if (ev_fall && n_q.cnt == 4'd8) begin
                        if (n_q.idx < WR_LIMIT) begin
                            for (int i = 0; i < NUM_WR; i++) begin
                                if (n_q.idx == IDX_W'(i)) begin
                                    n_d.regs[i] = n_q.sh;
                                end
                            end
                            n_d.idx = n_q.idx + 1'b1;
                            n_d.oe  = 1'b1;
                            n_d.st  = ST_ACK_WR;
                        end else begin
                            n_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ACK_WR: begin
                    if (ev_fall) begin
                        n_d.oe  = 1'b0;
                        n_d.cnt = 4'd0;
                        n_d.st  = ST_WR;
                    end
                end
                ST_RD: begin
                    if (ev_fall) begin
                        snap_shift = 1'b1;
                        if (n_q.cnt == 4'd7) begin
                            n_d.oe    = 1'b0;
                            n_d.st    = ST_RD_ACK;
                            n_d.idx   = n_q.idx + 1'b1;
                            n_d.rearm = (n_q.idx == RD_LAST);
                        end else begin
                            n_d.cnt = n_q.cnt + 4'd1;
                            n_d.oe  = ~snap_next;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev_rise) begin
                        if (sda_i || n_q.idx == RD_LIMIT) begin
                            n_d.st = ST_IDLE;
                        end else begin
                            n_d.st = ST_RD_NEXT;
                        end
                    end
                end
                ST_RD_NEXT: begin
                    if (ev_fall) begin
                        n_d.st  = ST_RD;
                        n_d.cnt = 4'd0;
                        n_d.oe  = ~snap_msb;
                    end
                end
                default: n_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '{st: ST_IDLE, cnt: 4'd0, sh: '0, rw: 1'b0, idx: '0,
                     oe: 1'b0, rearm: 1'b0, regs: '0};
        end else begin
            n_q <= n_d;
        end
    end

    assign sda_oe_o = n_q.oe;
    assign ctrl_o   = n_q.regs;
    assign rearm_o  = n_q.rearm;

    // SDA drive starts only while SCL is low
    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(n_q.oe) |-> !scl_i);

    // A control byte changes only together with its acknowledge drive
    assert_commit_with_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.regs != $past(n_q.regs)) |-> n_q.oe);

    // Re-arm is a single-cycle pulse
    assert_rearm_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        n_q.rearm |=> !n_q.rearm);

    // Re-arm only after the last read byte has been shifted out
    assert_rearm_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        n_q.rearm |-> (n_q.st == ST_RD_ACK && n_q.idx == RD_LIMIT));

    // An idle slave never holds SDA
    assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (n_q.st == ST_IDLE) |-> !n_q.oe);

endmodule

// File: tb/amp_ctl_i2c_slave_bench.sv
module amp_ctl_i2c_slave_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [31:0] status = 32'h0;
    logic [15:0] ctrl;
    logic        rearm;

    int checks = 0;
    int failures = 0;
    int rearm_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    amp_ctl_i2c_slave u_amp_ctl_i2c_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_line),
        .sda_oe_o(sda_oe),
        .status_i(status),
        .ctrl_o  (ctrl),
        .rearm_o (rearm)
    );

    always @(negedge clk) if (rearm) rearm_cnt++;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [1:0] n;
        logic       ack;
        logic [7:0] ea;
        logic [7:0] eb;
    } wvec_t;

    localparam wvec_t WVEC [5] = '{
        '{8'hD8, 8'h5A, 8'h13, 2'd2, 1'b1, 8'h5A, 8'h13},
        '{8'hD8, 8'hFF, 8'h00, 2'd2, 1'b1, 8'hFF, 8'h00},
        '{8'hDA, 8'h11, 8'h22, 2'd2, 1'b0, 8'hFF, 8'h00},
        '{8'hD8, 8'h41, 8'h99, 2'd1, 1'b1, 8'h41, 8'h00},
        '{8'hD8, 8'h00, 8'h1F, 2'd2, 1'b1, 8'h00, 8'h1F}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(2);
        scl = 1'b1;   tick(4);
        sda_m = 1'b0; tick(4);
        scl = 1'b0;   tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(2);
        scl = 1'b1;   tick(4);
        sda_m = 1'b1; tick(4);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;  tick(2);
        scl = 1'b1; tick(4);
        scl = 1'b0; tick(2);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(2);
        scl = 1'b1;   tick(2);
        b = sda_line; tick(2);
        scl = 1'b0;   tick(2);
    endtask

    // Returns 1 when the slave acknowledged
    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic master_ack);
        logic b;
        v = 8'h0;
        for (int i = 0; i < 8; i++) begin
            recv_bit(b);
            v = {v[6:0], b};
        end
        send_bit(~master_ack);
    endtask

    function automatic logic [7:0] exp_byte(input int i, input logic [31:0] st,
                                            input logic [7:0] a, input logic [7:0] b);
        logic [7:0] v;
        v = st[31-8*i -: 8];
        if (i == 2) v = {b[4], a[6], v[5:0]};
        if (i == 3) v = {2'b00, v[5:0]};
        return v;
    endfunction

    task automatic write2(input logic [7:0] a, input logic [7:0] b);
        logic k;
        bus_start();
        send_byte(8'hD8, k);
        send_byte(a, k);
        send_byte(b, k);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic        k;
        logic [7:0]  v;
        logic [7:0]  ma, mb;
        logic [31:0] st;
        int          r0;

        tick(3);
        // R12: reset state
        check(ctrl == 16'h0, "R12 ctrl in reset", 32'(ctrl), 0);
        check(sda_oe == 1'b0 && rearm == 1'b0, "R12 outputs in reset", {sda_oe, rearm}, 0);
        rst_n = 1'b1;
        tick(4);

        // R1/R2: vector table of write transactions
        foreach (WVEC[i]) begin
            bus_start();
            send_byte(WVEC[i].addr, k);
            check(k == WVEC[i].ack, "R1 address acknowledge", 32'(k), 32'(WVEC[i].ack));
            if (k) begin
                send_byte(WVEC[i].d0, k);
                check(k, "R2 first byte ack", 32'(k), 1);
                if (WVEC[i].n == 2'd2) begin
                    send_byte(WVEC[i].d1, k);
                    check(k, "R2 second byte ack", 32'(k), 1);
                end
            end
            bus_stop();
            check(ctrl == {WVEC[i].eb, WVEC[i].ea}, "R2 control bytes",
                  32'(ctrl), 32'({WVEC[i].eb, WVEC[i].ea}));
        end

        // R3: third byte is refused and ignored
        bus_start();
        send_byte(8'hD8, k);
        send_byte(8'h12, k);
        send_byte(8'h34, k);
        send_byte(8'h56, k);
        check(!k, "R3 third byte nack", 32'(k), 0);
        bus_stop();
        check(ctrl == 16'h3412, "R3 control unchanged", 32'(ctrl), 32'h3412);

        // R4/R5: field positions
        write2(8'h40, 8'h10);
        check(ctrl[6] == 1'b1 && ctrl[7:0] == 8'h40, "R4 diagnostics enable bit 6", 32'(ctrl[7:0]), 32'h40);
        check(ctrl[12] == 1'b1 && ctrl[15:8] == 8'h10, "R5 running bit 4", 32'(ctrl[15:8]), 32'h10);
        ma = 8'h40; mb = 8'h10;

        // R6/R7/R9: full read
        status = 32'hA1B2_03D4;
        r0 = rearm_cnt;
        bus_start();
        send_byte(8'hD9, k);
        check(k, "R1 read address ack", 32'(k), 1);
        for (int i = 0; i < 4; i++) begin
            recv_byte(v, i < 3);
            check(v == exp_byte(i, status, ma, mb), (i == 2) ? "R7 echo byte" :
                  (i == 3) ? "R7 last byte" : "R6 read byte",
                  32'(v), 32'(exp_byte(i, status, ma, mb)));
        end
        bus_stop();
        check(rearm_cnt == r0 + 1, "R9 one re-arm pulse", rearm_cnt - r0, 1);

        // R8: snapshot frozen at address acknowledge
        write2(8'h00, 8'h0B);
        ma = 8'h00; mb = 8'h0B;
        st = 32'h1122_3344;
        status = st;
        bus_start();
        send_byte(8'hD9, k);
        status = 32'hFFFF_FFFF;
        for (int i = 0; i < 4; i++) begin
            recv_byte(v, i < 3);
            check(v == exp_byte(i, st, ma, mb), "R8 frozen snapshot",
                  32'(v), 32'(exp_byte(i, st, ma, mb)));
        end
        bus_stop();

        // R9/R10: early NACK, then further clocks ignored
        status = 32'h0000_0000;
        r0 = rearm_cnt;
        bus_start();
        send_byte(8'hD9, k);
        recv_byte(v, 1'b1);
        check(v == 8'h00, "R6 first byte zero", 32'(v), 0);
        recv_byte(v, 1'b0);
        recv_byte(v, 1'b0);
        check(v == 8'hFF, "R10 released after nack", 32'(v), 32'hFF);
        bus_stop();
        check(rearm_cnt == r0, "R9 no pulse on short read", rearm_cnt - r0, 0);

        // R11: repeated START aborts partial byte
        bus_start();
        send_byte(8'hD8, k);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        send_byte(8'hD8, k);
        check(k, "R11 address after repeated start", 32'(k), 1);
        send_byte(8'h3C, k);
        send_byte(8'h5A, k);
        bus_stop();
        check(ctrl == 16'h5A3C, "R11 write after repeated start", 32'(ctrl), 32'h5A3C);

        // R12: reset clears control
        rst_n = 1'b0;
        tick(2);
        check(ctrl == 16'h0 && sda_oe == 1'b0, "R12 reset mid-run", 32'(ctrl), 0);
        rst_n = 1'b1;
        tick(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule